// File: doc/BRIEF.md
# Stack-Top Register Exchange Sequencer

This controller swaps a 16-bit register pair with the 16-bit word that sits at the top of a byte-wide stack in memory. The opcode fetch that comes before it is handled elsewhere. Once that fetch has finished, a one-clock start pulse launches the exchange. The sequencer then runs four timed bus cycles on a simple synchronous memory port: read, read, write, write. It ends by loading the fetched word into the register pair.

The two bytes read from the stack go into a hidden temporary pair. The pointer steps up by one between the two reads and back down by one between the two writes. The original register contents are what get written to memory. The register pair takes its new value only after the final write. The stack pointer leaves the operation with the same value it entered with.

Top module: `stk_xchg_seq`

## Requirements
- R1: While reset is high, and in the clock after it is released, busy, done, mem_rd and mem_wr are low, and pair_out and sp_out are zero.
- R2: Clocks are counted after the clock edge that accepts start, so clock 1 is the first clock after that edge. With the default lengths (3, 4, 3, 5), mem_rd is high in exactly clocks 3 and 7, and mem_wr is high in exactly clocks 10 and 15. Each strobe lasts one clock, and the two strobes are never high together.
- R3: The first read uses mem_addr equal to the stack pointer given at start. Its byte becomes the low byte of the result.
- R4: The second read uses the start pointer plus one, modulo 2^16. Its byte becomes the high byte of the result.
- R5: The first write puts pair_in[15:8], as captured at start, at the start pointer plus one.
- R6: The second write puts pair_in[7:0], as captured at start, at the start pointer.
- R7: pair_out equals {second read byte, first read byte} from clock 16 onward. It keeps its previous value through clock 15. done is high for clock 16 only.
- R8: In clock 16, sp_out equals the start pointer. This also holds when the pointer wraps from 0xFFFF to 0x0000.
- R9: busy is high in clocks 1 to 15 and low in clock 16.
- R10: A start pulse that arrives while busy is high changes neither the addresses, the write data, the result nor sp_out.
- R11: mem_addr holds its value for every clock of a bus cycle. It changes only between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock launch pulse, honoured only when idle |
| sp_in | input | ADDR_W | Stack pointer at launch |
| pair_in | input | 2*BYTE_W | Register pair at launch |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe; data sampled at the end of this clock |
| mem_wr | output | 1 | Write strobe, one clock |
| mem_wdata | output | BYTE_W | Write data |
| mem_rdata | input | BYTE_W | Read data |
| pair_out | output | 2*BYTE_W | Register pair after the exchange |
| sp_out | output | ADDR_W | Stack pointer, equal to the launch value at the end |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, byte data, and bus cycles of 3, 4, 3 and 5 clocks. Because these lengths are unequal, a strobe placed in the wrong clock or a swapped cycle order shows up as a strobe at the wrong index. The 16-bit pointer makes the 0xFFFF to 0x0000 wrap reachable, which tests the increment and decrement at the address boundary. Back-to-back exchanges expose whether the result pair is updated too early.

// File: rtl/stk_xchg_pkg.sv
package stk_xchg_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_GET_LO,
      PH_GET_HI,
      PH_PUT_HI,
      PH_PUT_LO
   } xchg_phase_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/stk_xchg_timer.sv
module stk_xchg_timer #(
   parameter int MAX_LEN = 5,
   localparam int CW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   input  logic [CW-1:0] last_idx,
   output logic          last
);
   generate
      if (MAX_LEN < 1) begin : g_bad_len
         $error("stk_xchg_timer: MAX_LEN must be at least 1");
      end
      if (MAX_LEN == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || !run || last) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
         end
         assign last = (cnt == last_idx);

         p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
            run |-> (cnt <= last_idx));
      end
   endgenerate
endmodule

// File: rtl/stk_xchg_sp.sv
module stk_xchg_sp #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] sp_in,
   input  logic              step_up,
   input  logic              step_down,
   output logic [ADDR_W-1:0] sp_q,
   output logic [ADDR_W-1:0] sp_origin
);
   always_ff @(posedge clk) begin
      if (rst) begin
         sp_q      <= '0;
         sp_origin <= '0;
      end else if (load) begin
         sp_q      <= sp_in;
         sp_origin <= sp_in;
      end else if (step_up) begin
         sp_q <= sp_q + 1'b1;
      end else if (step_down) begin
         sp_q <= sp_q - 1'b1;
      end
   end

   p_no_both_steps_r8: assert property (@(posedge clk) disable iff (rst)
      !(step_up && step_down));
   p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
      (step_up && !load) |=> (sp_q == $past(sp_q) + 1'b1));
endmodule

// File: rtl/stk_xchg_bytes.sv
module stk_xchg_bytes #(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] pair_in,
   input  logic              cap_lo,
   input  logic              cap_hi,
   input  logic [BYTE_W-1:0] rdata,
   input  logic              commit,
   input  logic              sel_hi,
   output logic [BYTE_W-1:0] wdata,
   output logic [WORD_W-1:0] pair_out
);
   logic [BYTE_W-1:0] tmp_lo, tmp_hi;
   logic [WORD_W-1:0] pair_held;

   always_ff @(posedge clk) begin
      if (rst) begin
         tmp_lo    <= '0;
         tmp_hi    <= '0;
         pair_held <= '0;
         pair_out  <= '0;
      end else begin
         if (load)   pair_held <= pair_in;
         if (cap_lo) tmp_lo    <= rdata;
         if (cap_hi) tmp_hi    <= rdata;
         if (commit) pair_out  <= {tmp_hi, tmp_lo};
      end
   end

   assign wdata = sel_hi ? pair_held[WORD_W-1:BYTE_W] : pair_held[BYTE_W-1:0];

   p_pair_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(commit) |-> $stable(pair_out));
endmodule

// File: rtl/stk_xchg_seq.sv
module stk_xchg_seq #(
   parameter int ADDR_W     = 16,
   parameter int BYTE_W     = 8,
   parameter int GET_LO_LEN = 3,
   parameter int GET_HI_LEN = 4,
   parameter int PUT_HI_LEN = 3,
   parameter int PUT_LO_LEN = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic [ADDR_W-1:0]   sp_in,
   input  logic [2*BYTE_W-1:0] pair_in,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_rd,
   output logic                mem_wr,
   output logic [BYTE_W-1:0]   mem_wdata,
   input  logic [BYTE_W-1:0]   mem_rdata,
   output logic [2*BYTE_W-1:0] pair_out,
   output logic [ADDR_W-1:0]   sp_out,
   output logic                busy,
   output logic                done
);
   import stk_xchg_pkg::*;

   localparam int MAX_LEN = max4(GET_LO_LEN, GET_HI_LEN, PUT_HI_LEN, PUT_LO_LEN);
   localparam int CW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("stk_xchg_seq: ADDR_W must be at least 2");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("stk_xchg_seq: BYTE_W must be at least 1");
      end
      if (GET_LO_LEN < 1 || GET_HI_LEN < 1 || PUT_HI_LEN < 1 || PUT_LO_LEN < 1) begin : g_bad_len
         $error("stk_xchg_seq: every bus cycle needs at least one clock");
      end
   endgenerate

   xchg_phase_e   phase, phase_nx;
   logic          last, accept;
   logic [CW-1:0] last_idx;
   logic [ADDR_W-1:0] sp_q, sp_origin;

   assign accept = start && (phase == PH_IDLE);
   assign busy   = (phase != PH_IDLE);

   always_comb begin
      case (phase)
         PH_GET_LO: last_idx = CW'(GET_LO_LEN - 1);
         PH_GET_HI: last_idx = CW'(GET_HI_LEN - 1);
         PH_PUT_HI: last_idx = CW'(PUT_HI_LEN - 1);
         PH_PUT_LO: last_idx = CW'(PUT_LO_LEN - 1);
         default:   last_idx = '0;
      endcase
   end

   always_comb begin
      phase_nx = phase;
      case (phase)
         PH_IDLE:   if (accept) phase_nx = PH_GET_LO;
         PH_GET_LO: if (last)   phase_nx = PH_GET_HI;
         PH_GET_HI: if (last)   phase_nx = PH_PUT_HI;
         PH_PUT_HI: if (last)   phase_nx = PH_PUT_LO;
         PH_PUT_LO: if (last)   phase_nx = PH_IDLE;
         default:               phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         done  <= 1'b0;
      end else begin
         phase <= phase_nx;
         done  <= (phase == PH_PUT_LO) && last;
      end
   end

   assign mem_rd = last && ((phase == PH_GET_LO) || (phase == PH_GET_HI));
   assign mem_wr = last && ((phase == PH_PUT_HI) || (phase == PH_PUT_LO));

   stk_xchg_timer #(.MAX_LEN(MAX_LEN)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .run      (busy),
      .last_idx (last_idx),
      .last     (last)
   );

   stk_xchg_sp #(.ADDR_W(ADDR_W)) u_sp (
      .clk       (clk),
      .rst       (rst),
      .load      (accept),
      .sp_in     (sp_in),
      .step_up   (last && (phase == PH_GET_LO)),
      .step_down (last && (phase == PH_PUT_HI)),
      .sp_q      (sp_q),
      .sp_origin (sp_origin)
   );

   stk_xchg_bytes #(.BYTE_W(BYTE_W)) u_bytes (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .pair_in  (pair_in),
      .cap_lo   (mem_rd && (phase == PH_GET_LO)),
      .cap_hi   (mem_rd && (phase == PH_GET_HI)),
      .rdata    (mem_rdata),
      .commit   (mem_wr && (phase == PH_PUT_LO)),
      .sel_hi   (phase == PH_PUT_HI),
      .wdata    (mem_wdata),
      .pair_out (pair_out)
   );

   assign mem_addr = sp_q;
   assign sp_out   = sp_q;

   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   p_sp_restored_r8: assert property (@(posedge clk) disable iff (rst)
      done |-> (sp_out == sp_origin));
   p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> $stable(sp_origin));
   p_addr_stable_r11: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |=> $stable(mem_addr));
endmodule

// File: tb/tb_stk_xchg_seq.sv
module tb_stk_xchg_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] sp_in = '0;
   logic [15:0] pair_in = '0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [15:0] pair_out, sp_out;
   logic        busy, done;

   int checks = 0;
   int fails  = 0;
   logic [7:0] mem [16];

   always #10 clk = ~clk;

   always @(posedge clk) if (mem_wr) mem[mem_addr[3:0]] <= mem_wdata;
   assign mem_rdata = mem[mem_addr[3:0]];

   stk_xchg_seq dut (
      .clk(clk), .rst(rst), .start(start), .sp_in(sp_in), .pair_in(pair_in),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .pair_out(pair_out), .sp_out(sp_out), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_rd && !mem_wr, "R1 strobes in reset", {busy, done, mem_rd, mem_wr}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(pair_out == 16'h0 && sp_out == 16'h0, "R1 outputs after reset", {pair_out, sp_out}, 0);
      chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);
   endtask

   // one exchange; optionally fires a stray start during the run
   task automatic t_exchange(input logic [15:0] sp, input logic [15:0] pair,
                             input logic [7:0] lo, input logic [7:0] hi, input bit stray);
      logic [15:0] prev;
      logic [15:0] sp1;
      bit bad_rd, bad_wr, bad_busy, bad_done, bad_addr;
      prev = pair_out;
      sp1 = sp + 16'h1;
      mem[sp[3:0]]  = lo;
      mem[sp1[3:0]] = hi;
      sp_in = sp; pair_in = pair; start = 1'b1;
      bad_rd = 0; bad_wr = 0; bad_busy = 0; bad_done = 0; bad_addr = 0;
      for (int n = 1; n <= 16; n++) begin
         @(negedge clk);
         if (n == 1) begin start = 1'b0; sp_in = 16'h5A5A; pair_in = 16'h0F0F; end
         if (stray && n == 5) start = 1'b1;   // R10 stray start while busy
         if (stray && n == 6) start = 1'b0;
         if (mem_rd != (n == 3 || n == 7))  bad_rd = 1;
         if (mem_wr != (n == 10 || n == 15)) bad_wr = 1;
         if (busy != (n <= 15)) bad_busy = 1;
         if (done != (n == 16)) bad_done = 1;
         if (n <= 3 && mem_addr != sp) bad_addr = 1;
         if (n >= 4 && n <= 10 && mem_addr != sp1) bad_addr = 1;
         if (n >= 11 && n <= 15 && mem_addr != sp) bad_addr = 1;
         if (n == 3)  chk(mem_addr == sp,  "R3 first read address", mem_addr, sp);
         if (n == 7)  chk(mem_addr == sp1, "R4 second read address", mem_addr, sp1);
         if (n == 10) chk(mem_addr == sp1 && mem_wdata == pair[15:8], "R5 high write",
                          {mem_addr, mem_wdata}, {sp1, pair[15:8]});
         if (n == 15) begin
            chk(mem_addr == sp && mem_wdata == pair[7:0], "R6 low write",
                {mem_addr, mem_wdata}, {sp, pair[7:0]});
            chk(pair_out == prev, "R7 pair held until last write", pair_out, prev);
         end
         if (n == 16) begin
            chk(pair_out == {hi, lo}, "R7 result pair", pair_out, {hi, lo});
            chk(sp_out == sp, "R8 pointer restored", sp_out, sp);
            chk(mem[sp[3:0]] == pair[7:0] && mem[sp1[3:0]] == pair[15:8], "R5 R6 memory contents",
                {mem[sp1[3:0]], mem[sp[3:0]]}, pair);
         end
      end
      chk(!bad_rd, "R2 read strobe clocks", bad_rd, 0);
      chk(!bad_wr, "R2 write strobe clocks", bad_wr, 0);
      chk(!bad_busy, "R9 busy window", bad_busy, 0);
      chk(!bad_done, "R7 done pulse", bad_done, 0);
      chk(!bad_addr, stray ? "R10 addresses unaffected by stray start" : "R11 address stable per cycle", bad_addr, 0);
      @(negedge clk);
      chk(!busy && !done && pair_out == {hi, lo}, "R7 result kept after done", pair_out, {hi, lo});
   endtask

   task automatic t_basic();    t_exchange(16'h1234, 16'hABCD, 8'h11, 8'h22, 1'b0); endtask
   task automatic t_again();    t_exchange(16'h1234, 16'h2211, 8'hCD, 8'hAB, 1'b0); endtask
   task automatic t_wrap();     t_exchange(16'hFFFF, 16'h3C5A, 8'h77, 8'h88, 1'b0); endtask // R8 wrap
   task automatic t_stray();    t_exchange(16'h0106, 16'hBEEF, 8'h01, 8'h02, 1'b1); endtask // R10

   initial begin
      #2_000_000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      @(negedge clk);
      t_reset();
      t_basic();
      t_again();
      t_wrap();
      t_stray();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule